// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block tracks the producer and consumer positions of a circular queue of fixed-size command descriptors that a host and a processing engine share. The host reads a register to learn which slot it should fill next, then announces how many slots it has filled by writing a count. The engine retires descriptors in order; each retirement moves one entry from the "outstanding" tally to the "completed, not yet released" tally. The host reads the completed tally together with the index of the oldest completed entry, processes those entries, and hands them back by writing a release count.

Both pointers move by counts written to the block, never by writing an index directly. A completion interrupt is a level that follows the completed tally against a programmable threshold, so software silences it by raising the threshold to the queue depth and re-arms it by writing 0. A halt register gates the engine, a size register sets the depth, and counts that do not fit are clipped to what is legal while a sticky error bit records the event. The engine is represented by a request input that retires the oldest outstanding descriptor when allowed.

Top module: `desc_ring_ctl`

## Requirements
- R1: After a synchronous active-low reset the depth reads 1024, both indices and both tallies are 0, the halt bit reads 1, the error bits read 0 and `irq` is low.
- R2: A read of word 1 returns the next free slot index in bits [31:16] and zeros elsewhere.
- R3: Writing N to word 4 adds N to the outstanding tally and moves the free slot index forward by N modulo the depth.
- R4: Word 6 controls the engine: writing 0 lets it run, any other value halts it, and bit 0 of a read is 1 while halted. With `eng_req` high, `cmpl_pulse` is high in that same cycle only when running and the outstanding tally is nonzero; each pulse moves one entry to the completed tally at the next edge.
- R5: A read of word 2 returns the completed tally in bits [14:0] and the oldest completed index in bits [28:16].
- R6: Writing N to word 5 subtracts N from the completed tally and moves the oldest completed index forward by N modulo the depth.
- R7: `irq` is high exactly when the completed tally is nonzero and larger than the 15-bit threshold held in word 3; a threshold equal to the depth keeps it low.
- R8: An add larger than the free space (depth minus outstanding minus completed) accepts only the free space and sets error bit 0 of word 7.
- R9: A release larger than the completed tally releases only that tally and sets error bit 1 of word 7.
- R10: Error bits stay set until any write to word 7, which clears both.
- R11: Writing word 0 sets the depth, with 0 taken as 1 and values above 8192 taken as 8192; it also clears both indices and both tallies. A read of word 0 returns the depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe for the selected word |
| host_addr | input | 3 | Register word select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected word (combinational) |
| eng_req | input | 1 | Engine asks to retire the oldest outstanding descriptor |
| cmpl_pulse | output | 1 | A descriptor is retired in this cycle |
| irq | output | 1 | Completion interrupt level |

## Verification
Adds are tried below the free space, exactly filling it and past it, on a small ring so that the free slot index wraps, which separates correct modulo arithmetic and clipping from plain counting. Retire requests are given while halted, while running with work, and while running with nothing outstanding, which tells the gating terms apart. The threshold is swept below, at and above the completed tally and at the depth, and releases are given both within and beyond the completed tally, so off-by-one compares and missing clipping show up as wrong read-back values or interrupt level.

// File: rtl/desc_ring_pkg.sv
// Shared definitions for the descriptor ring pointer manager.
// Assumes a host register window of eight 32-bit words.
package desc_ring_pkg;

    typedef enum logic [2:0] {
        REG_SIZE   = 3'd0,
        REG_ALLOC  = 3'd1,
        REG_DONE   = 3'd2,
        REG_THRESH = 3'd3,
        REG_ADD    = 3'd4,
        REG_REL    = 3'd5,
        REG_HALT   = 3'd6,
        REG_ERR    = 3'd7
    } reg_sel_e;

    // Bit offset of index fields inside read words.
    localparam int IDX_FIELD_LSB = 16;

endpackage

// File: rtl/ring_step.sv
// Clips a requested count to a limit and advances a ring index by the
// accepted amount with wrap at the programmed depth.
// Assumes idx < depth and limit <= depth, so one subtraction wraps.
module ring_step #(
    parameter int CNT_W = 15
) (
    input  logic [CNT_W-1:0] idx,
    input  logic [CNT_W-1:0] req,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] depth,
    output logic [CNT_W-1:0] acc,
    output logic             sat,
    output logic [CNT_W-1:0] nxt
);
    logic [CNT_W:0] sum;

    // Clip the request and compute the wrapped next index.
    always_comb begin
        sat = (req > limit);
        acc = sat ? limit : req;
        sum = {1'b0, idx} + {1'b0, acc};
        if (sum >= {1'b0, depth})
            nxt = CNT_W'(sum - {1'b0, depth});
        else
            nxt = CNT_W'(sum);
    end
endmodule

// File: rtl/desc_ring_csr.sv
// Register decode and read multiplexer for the ring manager.
// Assumes CNT_W <= 16 and IDX_W <= 16 so fields fit their read words.
module desc_ring_csr
    import desc_ring_pkg::*;
#(
    parameter int IDX_W = 13,
    parameter int CNT_W = 15
) (
    input  logic             host_we,
    input  logic [2:0]       host_addr,
    input  logic [CNT_W-1:0] depth,
    input  logic [CNT_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] rd_idx,
    input  logic [CNT_W-1:0] pend,
    input  logic [CNT_W-1:0] thresh,
    input  logic             halted,
    input  logic [1:0]       err,
    output logic             we_size,
    output logic             we_thresh,
    output logic             we_add,
    output logic             we_rel,
    output logic             we_halt,
    output logic             we_err,
    output logic [31:0]      rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(host_addr);

    // Decode one write strobe per writable word.
    always_comb begin
        we_size   = host_we && (sel == REG_SIZE);
        we_thresh = host_we && (sel == REG_THRESH);
        we_add    = host_we && (sel == REG_ADD);
        we_rel    = host_we && (sel == REG_REL);
        we_halt   = host_we && (sel == REG_HALT);
        we_err    = host_we && (sel == REG_ERR);
    end

    // Assemble the read word for the selected register.
    always_comb begin
        rdata = '0;
        case (sel)
            REG_SIZE:   rdata[CNT_W-1:0] = depth;
            REG_ALLOC:  rdata[IDX_FIELD_LSB +: IDX_W] = wr_idx[IDX_W-1:0];
            REG_DONE: begin
                rdata[CNT_W-1:0] = pend;
                rdata[IDX_FIELD_LSB +: IDX_W] = rd_idx[IDX_W-1:0];
            end
            REG_THRESH: rdata[CNT_W-1:0] = thresh;
            REG_HALT:   rdata[0] = halted;
            REG_ERR:    rdata[1:0] = err;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/desc_ring_ctl.sv
// Producer/consumer bookkeeping for a circular descriptor queue.
// Host advances the free index by add counts and the completed index by
// release counts; the engine retires one descriptor per granted request.
// Assumes CNT_W > IDX_W so the depth value 2**IDX_W is representable.
module desc_ring_ctl
    import desc_ring_pkg::*;
#(
    parameter int IDX_W     = 13,
    parameter int CNT_W     = 15,
    parameter int DEF_DEPTH = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        eng_req,
    output logic        cmpl_pulse,
    output logic        irq
);
    localparam int          DEPTH_MAX = 1 << IDX_W;
    localparam logic [31:0] DMAX32    = 32'(DEPTH_MAX);

    logic [CNT_W-1:0] depth_q, wr_idx_q, rd_idx_q, outst_q, pend_q, thresh_q;
    logic             halted_q;
    logic [1:0]       err_q;

    logic             we_size, we_thresh, we_add, we_rel, we_halt, we_err;
    logic [CNT_W-1:0] wcount, free_cnt, add_req, rel_req;
    logic [CNT_W-1:0] add_acc, add_nxt, rel_acc, rel_nxt, size_val;
    logic             add_sat, rel_sat;
    logic [CNT_W-1:0] cmpl_ext;

    assign wcount   = host_wdata[CNT_W-1:0];
    assign free_cnt = depth_q - outst_q - pend_q;
    assign add_req  = we_add ? wcount : '0;
    assign rel_req  = we_rel ? wcount : '0;
    assign cmpl_ext = {{(CNT_W-1){1'b0}}, cmpl_pulse};

    // Engine retires the oldest outstanding entry when running.
    assign cmpl_pulse = eng_req && !halted_q && (outst_q != '0);

    // Interrupt level from completed tally against the threshold.
    assign irq = (pend_q != '0) && (pend_q > thresh_q);

    // Clamp a programmed depth into [1, DEPTH_MAX].
    always_comb begin
        if (host_wdata == 32'd0)
            size_val = CNT_W'(1);
        else if (host_wdata > DMAX32)
            size_val = CNT_W'(DEPTH_MAX);
        else
            size_val = CNT_W'(host_wdata);
    end

    desc_ring_csr #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_csr (
        .host_we   (host_we),
        .host_addr (host_addr),
        .depth     (depth_q),
        .wr_idx    (wr_idx_q),
        .rd_idx    (rd_idx_q),
        .pend      (pend_q),
        .thresh    (thresh_q),
        .halted    (halted_q),
        .err       (err_q),
        .we_size   (we_size),
        .we_thresh (we_thresh),
        .we_add    (we_add),
        .we_rel    (we_rel),
        .we_halt   (we_halt),
        .we_err    (we_err),
        .rdata     (host_rdata)
    );

    // Producer side: clip add to free space, wrap the free index.
    ring_step #(.CNT_W(CNT_W)) u_add (
        .idx   (wr_idx_q),
        .req   (add_req),
        .limit (free_cnt),
        .depth (depth_q),
        .acc   (add_acc),
        .sat   (add_sat),
        .nxt   (add_nxt)
    );

    // Consumer side: clip release to completed tally, wrap the done index.
    ring_step #(.CNT_W(CNT_W)) u_rel (
        .idx   (rd_idx_q),
        .req   (rel_req),
        .limit (pend_q),
        .depth (depth_q),
        .acc   (rel_acc),
        .sat   (rel_sat),
        .nxt   (rel_nxt)
    );

    // Ring geometry, indices and tallies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q  <= CNT_W'(DEF_DEPTH);
            wr_idx_q <= '0;
            rd_idx_q <= '0;
            outst_q  <= '0;
            pend_q   <= '0;
        end else if (we_size) begin
            depth_q  <= size_val;
            wr_idx_q <= '0;
            rd_idx_q <= '0;
            outst_q  <= '0;
            pend_q   <= '0;
        end else begin
            wr_idx_q <= add_nxt;
            rd_idx_q <= rel_nxt;
            outst_q  <= outst_q + add_acc - cmpl_ext;
            pend_q   <= pend_q - rel_acc + cmpl_ext;
        end
    end

    // Threshold, halt control and sticky error bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh_q <= '0;
            halted_q <= 1'b1;
            err_q    <= '0;
        end else begin
            if (we_thresh) thresh_q <= wcount;
            if (we_halt)   halted_q <= (host_wdata != 32'd0);
            if (we_err)    err_q <= '0;
            else           err_q <= err_q | {rel_sat, add_sat};
        end
    end
endmodule

// File: rtl/desc_ring_chk.sv
// Property checker for desc_ring_ctl, attached by bind below.
// Assumes the register word numbering of desc_ring_pkg.
module desc_ring_chk #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_we,
    input logic [2:0]       host_addr,
    input logic [31:0]      host_wdata,
    input logic             cmpl_pulse,
    input logic             irq,
    input logic [CNT_W-1:0] depth_q,
    input logic [CNT_W-1:0] wr_idx_q,
    input logic [CNT_W-1:0] rd_idx_q,
    input logic [CNT_W-1:0] outst_q,
    input logic [CNT_W-1:0] pend_q,
    input logic             halted_q,
    input logic [1:0]       err_q
);
    logic [CNT_W:0] used;
    logic           add_wr, err_wr;
    assign used   = {1'b0, outst_q} + {1'b0, pend_q};
    assign add_wr = host_we && (host_addr == 3'd4);
    assign err_wr = host_we && (host_addr == 3'd7);

    p_capacity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        used <= {1'b0, depth_q});

    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx_q < depth_q) && (rd_idx_q < depth_q));

    p_add_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        add_wr && ({1'b0, host_wdata[CNT_W-1:0]} + used > {1'b0, depth_q})
        |=> err_q[0]);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != 2'b00) && !err_wr |=> ((err_q & $past(err_q)) == $past(err_q)));

    p_cmpl_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_pulse && !host_we |=> pend_q == $past(pend_q) + 1'b1);

    p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q && !host_we |=> $stable(outst_q));

    p_irq_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_q != '0));
endmodule

bind desc_ring_ctl desc_ring_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .cmpl_pulse (cmpl_pulse),
    .irq        (irq),
    .depth_q    (depth_q),
    .wr_idx_q   (wr_idx_q),
    .rd_idx_q   (rd_idx_q),
    .outst_q    (outst_q),
    .pend_q     (pend_q),
    .halted_q   (halted_q),
    .err_q      (err_q)
);

// File: tb/sim_desc_ring_ctl.sv
`timescale 1ns/1ps
module sim_desc_ring_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        eng_req = 1'b0;
    logic        cmpl_pulse, irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    desc_ring_ctl u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_req(eng_req),
        .cmpl_pulse(cmpl_pulse), .irq(irq)
    );

    // Vector: {is_write, word, data, requirement number}
    localparam int NV = 23;
    localparam logic [43:0] VEC [NV] = '{
        {1'b0, 3'd0, 32'd1024,     8'd11},  // R11 default depth
        {1'b0, 3'd1, 32'h0,        8'd2},   // R2 free index 0
        {1'b1, 3'd4, 32'd5,        8'd3},   // R3 add 5
        {1'b0, 3'd1, 32'h0005_0000,8'd3},
        {1'b1, 3'd0, 32'd8,        8'd11},  // R11 depth 8 clears state
        {1'b0, 3'd0, 32'd8,        8'd11},
        {1'b0, 3'd1, 32'h0,        8'd11},
        {1'b1, 3'd4, 32'd6,        8'd3},
        {1'b0, 3'd1, 32'h0006_0000,8'd3},
        {1'b1, 3'd4, 32'd3,        8'd8},   // R8 only 2 fit, index wraps
        {1'b0, 3'd1, 32'h0,        8'd8},
        {1'b0, 3'd7, 32'd1,        8'd8},
        {1'b1, 3'd7, 32'd0,        8'd10},  // R10 clear
        {1'b0, 3'd7, 32'd0,        8'd10},
        {1'b1, 3'd5, 32'd1,        8'd9},   // R9 nothing completed
        {1'b0, 3'd7, 32'd2,        8'd9},
        {1'b0, 3'd2, 32'd0,        8'd9},
        {1'b1, 3'd0, 32'd0,        8'd11},  // R11 zero taken as 1
        {1'b0, 3'd0, 32'd1,        8'd11},
        {1'b1, 3'd0, 32'h0001_0000,8'd11},  // R11 clamp to 8192
        {1'b0, 3'd0, 32'd8192,     8'd11},
        {1'b1, 3'd0, 32'd8,        8'd11},
        {1'b0, 3'd6, 32'd1,        8'd4}    // R4 halted by default
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    // One cycle of engine request; checks the same-cycle completion strobe.
    task automatic eng(input logic exp, input string tag);
        @(negedge clk);
        eng_req = 1'b1;
        #1;
        check(tag, {31'd0, cmpl_pulse}, {31'd0, exp});
        @(negedge clk);
        eng_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, 32'd1024, "R1 depth");
        rd(3'd1, 32'd0, "R1 free index");
        rd(3'd2, 32'd0, "R1 done word");
        rd(3'd6, 32'd1, "R1 halted");
        rd(3'd7, 32'd0, "R1 errors");
        check("R1 irq", {31'd0, irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][43])
                wr(VEC[i][42:40], VEC[i][39:8]);
            else
                rd(VEC[i][42:40], VEC[i][39:8], $sformatf("R%0d vec%0d", VEC[i][7:0], i));
        end

        // Directed: depth 8, empty ring
        wr(3'd7, 32'd0);
        wr(3'd4, 32'd4);
        eng(1'b0, "R4 halted no retire");
        eng(1'b0, "R4 halted no retire");
        rd(3'd2, 32'd0, "R4 nothing completed while halted");
        wr(3'd6, 32'd0);
        rd(3'd6, 32'd0, "R4 running");
        eng(1'b1, "R4 retire 1");
        eng(1'b1, "R4 retire 2");
        eng(1'b1, "R4 retire 3");
        rd(3'd2, 32'd3, "R5 three completed at index 0");
        check("R7 irq thr0", {31'd0, irq}, 32'd1);
        wr(3'd3, 32'd3);
        check("R7 irq thr equal", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'd2);
        check("R7 irq thr below", {31'd0, irq}, 32'd1);
        wr(3'd3, 32'd8);
        check("R7 irq thr depth", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'd0);
        check("R7 irq rearmed", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'd2);
        rd(3'd2, 32'h0002_0001, "R6 release 2");
        check("R7 irq one left", {31'd0, irq}, 32'd1);
        eng(1'b1, "R4 last outstanding");
        eng(1'b0, "R4 none outstanding");
        eng(1'b0, "R4 none outstanding");
        rd(3'd2, 32'h0002_0002, "R5 two completed at index 2");
        wr(3'd4, 32'd6);
        rd(3'd1, 32'h0002_0000, "R3 exact fill wraps to 2");
        rd(3'd7, 32'd0, "R8 exact fill no error");
        wr(3'd5, 32'd5);
        rd(3'd2, 32'h0004_0000, "R9 release clipped to 2");
        rd(3'd7, 32'd2, "R9 error bit 1");
        check("R7 irq empty", {31'd0, irq}, 32'd0);
        wr(3'd6, 32'd1);
        rd(3'd6, 32'd1, "R4 halted again");
        eng(1'b0, "R4 halted with work");

        // R1 reset from a busy state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd0, 32'd1024, "R1 depth after reset");
        rd(3'd1, 32'd0, "R1 free index after reset");
        rd(3'd2, 32'd0, "R1 done after reset");
        rd(3'd7, 32'd0, "R1 errors after reset");
        rd(3'd6, 32'd1, "R1 halted after reset");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule